// File: doc/BRIEF.md
# Coprocessor Error Check and Trap Dispatch

This block sits on the host CPU side of a numeric coprocessor. The decoder gives it a class for every instruction it starts. The block then decides one of three outcomes for that instruction: a trap, a hand-off of the instruction to the coprocessor, or nothing at all.

Coprocessor errors are reported late. The coprocessor raises its error line after an instruction has failed. The host looks at that line only when a later WAIT starts, or when a later escape instruction starts that is not in the no-wait group. The no-wait group covers clear-exceptions, initialise, save state, set protected mode, and the stores of control word, environment and status. A pending error seen at such a check point raises vector 16.

Before it forwards an escape instruction, the block also applies the CPU's own operand address check. A violation raises vector 13 with a zero error code, and the instruction is never forwarded.

Top module: `cpx_trap_gate`

## Requirements
- R1: After reset, and until the first instruction start, `trap_req` and `cp_fwd` are low and `trap_vec` and `trap_code` are zero.
- R2: `insn_class` uses these codes: 3'b000 plain (non-escape), 3'b001 WAIT, 3'b010 checked escape, 3'b011 no-wait escape. Codes 3'b100 to 3'b111 count as plain. A plain instruction never traps and is never forwarded, whatever `cp_error` and `addr_fault` are.
- R3: A WAIT or checked escape that starts while the synchronized error is high raises `trap_req` one cycle after the start edge, with `trap_vec` = 16 and `trap_code` = 0.
- R4: A no-wait escape without an address fault is forwarded (`cp_fwd` high one cycle after the start edge) even while the error is high, and it does not trap.
- R5: A checked or no-wait escape that starts with `addr_fault` high raises `trap_req` with `trap_vec` = 13 and `trap_code` = 0, and it is not forwarded.
- R6: When an address fault and a pending error apply to the same instruction, vector 13 wins.
- R7: `trap_req` and `cp_fwd` are never high together. Each is high for exactly one cycle per instruction start.
- R8: A checked escape with no error and no fault is forwarded one cycle after its start edge. A WAIT with no error produces no output.
- R9: `cp_error` is acted on only at an instruction start. With no start, no trap is ever raised, and an error that clears before the next check point causes no trap.
- R10: `cp_error` passes through `ERR_SYNC` flops before it is examined. A level that arrives fewer than `ERR_SYNC` edges before the start edge is not yet seen.
- R11: A WAIT ignores `addr_fault`, because it has no memory operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_start | input | 1 | One-cycle strobe marking the start of an instruction |
| insn_class | input | 3 | Class code of the starting instruction |
| addr_fault | input | 1 | Operand address check failed for this instruction |
| cp_error | input | 1 | Error line from the coprocessor (asynchronous level) |
| trap_req | output | 1 | One-cycle trap request |
| trap_vec | output | VEC_W (8) | Trap vector number, valid with `trap_req` |
| trap_code | output | CODE_W (16) | Error code pushed with the trap |
| cp_fwd | output | 1 | One-cycle strobe handing the instruction to the coprocessor |

## Verification
The bench builds the block with its default parameters: two error synchronizer stages, an 8-bit vector and a 16-bit code, with vectors 16 and 13. Because there are two stages, the bench can raise the error only one edge before a check point and confirm that the error is not yet seen. The same instruction then traps once the error has been held for longer.

The 8-bit vector width carries both vector numbers without truncation. Every class code is driven against every combination of error level and address fault that matters for it, including the four reserved codes.

// File: rtl/cpx_trap_pkg.sv
package cpx_trap_pkg;
   localparam int CLASS_W = 3;
   localparam logic [CLASS_W-1:0] CLS_PLAIN   = 3'b000;
   localparam logic [CLASS_W-1:0] CLS_WAIT    = 3'b001;
   localparam logic [CLASS_W-1:0] CLS_ESC_CHK = 3'b010;
   localparam logic [CLASS_W-1:0] CLS_ESC_NOW = 3'b011;

   typedef enum logic [1:0] {
      OUT_NONE = 2'd0,
      OUT_FWD  = 2'd1,
      OUT_GP   = 2'd2,
      OUT_PE   = 2'd3
   } outcome_e;
endpackage

// File: rtl/cpx_err_sync.sv
module cpx_err_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic err_raw,
   output logic err_sync
);
   initial assert (STAGES >= 1 && STAGES <= 4)
      else $error("cpx_err_sync: STAGES must be 1..4");

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= err_raw;
         end
         assign err_sync = q;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], err_raw};
         end
         assign err_sync = sh[STAGES-1];

         // R10: each stage carries the previous stage's value one edge later
         for (genvar s = 1; s < STAGES; s++) begin : g_chk
            a_r10_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
               sh[s] == $past(sh[s-1]));
         end
      end
   endgenerate
endmodule

// File: rtl/cpx_class_decode.sv
module cpx_class_decode
   import cpx_trap_pkg::*;
(
   input  logic [CLASS_W-1:0] cls,
   output logic               is_esc,
   output logic               samples_err,
   output logic               has_operand
);
   always_comb begin
      is_esc      = 1'b0;
      samples_err = 1'b0;
      unique case (cls)
         CLS_WAIT:    samples_err = 1'b1;
         CLS_ESC_CHK: begin is_esc = 1'b1; samples_err = 1'b1; end
         CLS_ESC_NOW: is_esc = 1'b1;
         default:     ;
      endcase
      has_operand = is_esc;
   end
endmodule

// File: rtl/cpx_trap_arbiter.sv
module cpx_trap_arbiter
   import cpx_trap_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int CODE_W = 16,
   parameter int PE_VEC = 16,
   parameter int GP_VEC = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_esc,
   input  logic              samples_err,
   input  logic              has_operand,
   input  logic              addr_fault,
   input  logic              err_s,
   output logic              trap_req,
   output logic [VEC_W-1:0]  trap_vec,
   output logic [CODE_W-1:0] trap_code,
   output logic              cp_fwd
);
   localparam logic [VEC_W-1:0] PE_V = VEC_W'(PE_VEC);
   localparam logic [VEC_W-1:0] GP_V = VEC_W'(GP_VEC);

   initial assert (VEC_W >= 1 && VEC_W <= 16 && PE_VEC < (1 << VEC_W) && GP_VEC < (1 << VEC_W))
      else $error("cpx_trap_arbiter: vector does not fit VEC_W");
   initial assert (PE_VEC != GP_VEC)
      else $error("cpx_trap_arbiter: vectors must differ");
   initial assert (CODE_W >= 1)
      else $error("cpx_trap_arbiter: CODE_W must be positive");

   outcome_e pick;
   always_comb begin
      pick = OUT_NONE;
      if (start) begin
         if (has_operand && addr_fault)  pick = OUT_GP;
         else if (samples_err && err_s)  pick = OUT_PE;
         else if (is_esc)                pick = OUT_FWD;
      end
   end

   outcome_e res_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= OUT_NONE;
      else        res_q <= pick;
   end

   always_comb begin
      trap_req  = (res_q == OUT_GP) || (res_q == OUT_PE);
      cp_fwd    = (res_q == OUT_FWD);
      trap_code = '0;
      unique case (res_q)
         OUT_GP:  trap_vec = GP_V;
         OUT_PE:  trap_vec = PE_V;
         default: trap_vec = '0;
      endcase
   end

   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_req && cp_fwd));
   a_r9_quiet_without_start: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !trap_req && !cp_fwd);
   a_r5_gp_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      start && is_esc && addr_fault |=> trap_req && trap_vec == GP_V && trap_code == '0 && !cp_fwd);
   a_r3_pe_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      start && samples_err && err_s && !(is_esc && addr_fault) |=> trap_req && trap_vec == PE_V);
endmodule

// File: rtl/cpx_trap_gate.sv
module cpx_trap_gate
   import cpx_trap_pkg::*;
#(
   parameter int ERR_SYNC = 2,
   parameter int VEC_W    = 8,
   parameter int CODE_W   = 16,
   parameter int PE_VEC   = 16,
   parameter int GP_VEC   = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               insn_start,
   input  logic [CLASS_W-1:0] insn_class,
   input  logic               addr_fault,
   input  logic               cp_error,
   output logic               trap_req,
   output logic [VEC_W-1:0]   trap_vec,
   output logic [CODE_W-1:0]  trap_code,
   output logic               cp_fwd
);
   logic err_s, is_esc, samples_err, has_operand;

   cpx_err_sync #(.STAGES(ERR_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .err_raw(cp_error), .err_sync(err_s));

   cpx_class_decode u_dec (
      .cls(insn_class), .is_esc(is_esc), .samples_err(samples_err),
      .has_operand(has_operand));

   cpx_trap_arbiter #(
      .VEC_W(VEC_W), .CODE_W(CODE_W), .PE_VEC(PE_VEC), .GP_VEC(GP_VEC)
   ) u_arb (
      .clk(clk), .rst_n(rst_n), .start(insn_start), .is_esc(is_esc),
      .samples_err(samples_err), .has_operand(has_operand),
      .addr_fault(addr_fault), .err_s(err_s), .trap_req(trap_req),
      .trap_vec(trap_vec), .trap_code(trap_code), .cp_fwd(cp_fwd));

   a_r2_plain_silent: assert property (@(posedge clk) disable iff (!rst_n)
      insn_start && (insn_class == CLS_PLAIN || insn_class[2]) |=> !trap_req && !cp_fwd);
   a_r4_nowait_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      insn_start && insn_class == CLS_ESC_NOW && !addr_fault |=> cp_fwd && !trap_req);
   a_r11_wait_ignores_fault: assert property (@(posedge clk) disable iff (!rst_n)
      insn_start && insn_class == CLS_WAIT && !err_s |=> !trap_req && !cp_fwd);
endmodule

// File: tb/test_cpx_trap_gate.sv
module test_cpx_trap_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_start = 1'b0;
   logic [2:0]  insn_class = 3'b000;
   logic        addr_fault = 1'b0;
   logic        cp_error = 1'b0;
   logic        trap_req, cp_fwd;
   logic [7:0]  trap_vec;
   logic [15:0] trap_code;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   cpx_trap_gate i_cpx_trap_gate (
      .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_class(insn_class),
      .addr_fault(addr_fault), .cp_error(cp_error), .trap_req(trap_req),
      .trap_vec(trap_vec), .trap_code(trap_code), .cp_fwd(cp_fwd));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_err(input logic v);
      @(negedge clk); cp_error = v;
      repeat (3) @(negedge clk);
   endtask

   // exp: 0 none, 1 forward, 13/16 trap vector
   task automatic issue(input string req, input logic [2:0] cls, input logic flt, input int exp);
      @(negedge clk);
      insn_class = cls; addr_fault = flt; insn_start = 1'b1;
      @(posedge clk); #1;
      chk(req, trap_req, (exp == 13 || exp == 16) ? 1 : 0);
      chk(req, trap_vec, (exp == 13 || exp == 16) ? exp : 0);
      chk(req, trap_code, 0);
      chk(req, cp_fwd, (exp == 1) ? 1 : 0);
      @(negedge clk);
      insn_start = 1'b0; addr_fault = 1'b0; insn_class = 3'b000;
      @(posedge clk); #1;
      chk({req, " R7 one cycle"}, trap_req, 0);
      chk({req, " R7 one cycle"}, cp_fwd, 0);
   endtask

   task automatic t_reset;
      #23;
      chk("R1 trap_req", trap_req, 0);
      chk("R1 cp_fwd", cp_fwd, 0);
      chk("R1 trap_vec", trap_vec, 0);
      chk("R1 trap_code", trap_code, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 after release", trap_req | cp_fwd, 0);
   endtask

   task automatic t_clean;
      issue("R8 checked esc forwarded", 3'b010, 1'b0, 1);
      issue("R8 wait no error", 3'b001, 1'b0, 0);
      issue("R4 nowait clean", 3'b011, 1'b0, 1);
      issue("R11 wait ignores fault", 3'b001, 1'b1, 0);
   endtask

   task automatic t_error_paths;
      set_err(1'b1);
      issue("R3 checked esc error", 3'b010, 1'b0, 16);
      issue("R3 wait error", 3'b001, 1'b0, 16);
      issue("R4 nowait with error", 3'b011, 1'b0, 1);
      issue("R6 fault beats error", 3'b010, 1'b1, 13);
      issue("R11 wait fault error", 3'b001, 1'b1, 16);
      set_err(1'b0);
   endtask

   task automatic t_fault;
      issue("R5 checked esc fault", 3'b010, 1'b1, 13);
      issue("R5 nowait fault", 3'b011, 1'b1, 13);
   endtask

   task automatic t_plain;
      set_err(1'b1);
      for (int c = 0; c < 8; c++) begin
         if (c == 0 || c >= 4) begin
            issue("R2 plain with error", 3'(c), 1'b0, 0);
            issue("R2 plain with fault", 3'(c), 1'b1, 0);
         end
      end
      set_err(1'b0);
   endtask

   task automatic t_no_start;
      @(negedge clk); cp_error = 1'b1;
      for (int k = 0; k < 10; k++) begin
         @(posedge clk); #1;
         chk("R9 no start no trap", trap_req, 0);
      end
      set_err(1'b0);
      issue("R9 error cleared before check", 3'b010, 1'b0, 1);
   endtask

   task automatic t_sync_delay;
      // error raised one edge before the start edge: not yet through 2 flops
      @(negedge clk); cp_error = 1'b1;
      issue("R10 late error unseen", 3'b010, 1'b0, 1);
      issue("R10 error now seen", 3'b010, 1'b0, 16);
      set_err(1'b0);
   endtask

   initial begin
      t_reset();
      t_clean();
      t_error_paths();
      t_fault();
      t_plain();
      t_no_start();
      t_sync_delay();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule